// File: doc/BRIEF.md
# Programmable Period Timer with Command Register

This block is a 16-bit down-counting timer. Software reaches it through a byte-wide strobe interface. The period is held in two byte registers. A write-only command port sets the interrupt enable, the run mode (single-shot or re-triggerable), pin routing and the run state. The same port reads back as an interrupt status byte. The timer counts once per clock. Each time it expires it sets a pending flag, and it can toggle an output pin, so the pin frequency is the clock divided by twice the period.

The period registers are read back as they were written, never as the live count. A period of zero keeps the timer from running. A reset command returns every control setting to its default and clears the pending flag. It does not touch the period registers.

Top module: `period_timer`

## Requirements
- R1: After hardware reset both period bytes read 0x00, the control address reads 0x00, `irq` is 0, `tmr_out` is 0 and the timer is stopped.
- R2: Address 0 holds the low byte of the period and address 1 the high byte. A read returns the programmed byte in `rdata` one clock after the `rd_en` cycle. Address 3 reads 0x00.
- R3: The start command (control write with `wdata[3:0]`=5) loads the period P = {high, low} and counts down once per clock. Time-outs fall P clocks after the start write is captured, and every P clocks after that.
- R4: With a period of zero no time-out ever occurs. A start command is then ignored, and a timer that is running stops when its period is rewritten to zero.
- R5: A control read returns 0x01 when the interrupt is enabled (code 1) and a time-out is pending, and 0x00 otherwise. A command is never read back.
- R6: In single-shot mode (code 3) exactly one time-out follows a start, and the timer then stops.
- R7: In re-triggerable mode (code 4, the default) the counter reloads the period on every time-out and keeps running.
- R8: Each time-out sets the pending flag and a control read clears it. When a read and a time-out fall in the same cycle, the flag stays set.
- R9: `irq` is high exactly while the interrupt is enabled and a time-out is pending. Disable (code 2) drops `irq` without clearing the pending flag, and a later enable raises `irq` again.
- R10: When routed (code 8), `tmr_out` toggles on every time-out. When unrouted (code 9), `tmr_out` is held at 0.
- R11: The reset command (code 7) sets the defaults: interrupt disabled, re-triggerable, unrouted, stopped, nothing pending. Both period bytes are left unchanged.
- R12: Stop (code 6) halts counting. Codes 0 and 10 to 15 are ignored. Bits [7:4] of a control write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and interface clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| wdata | input | 8 | Write data; command code in bits [3:0] at address 2 |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request |
| tmr_out | output | 1 | Routed time-out toggle pin |

## Verification
Two events can land in the same cycle: a time-out setting the pending flag, and a control read clearing it. The bench starts a period-4 timer and times a control read so it is captured on the very edge of the second time-out. It then requires `irq` to stay high after the read, and requires a second, off-beat read to bring `irq` low. A disable command is also placed on a time-out edge. This confirms that the pending flag survives while `irq` falls and comes back on re-enable.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_IRQ_ON  = 4'd1,
    CMD_IRQ_OFF = 4'd2,
    CMD_ONCE    = 4'd3,
    CMD_REPEAT  = 4'd4,
    CMD_START   = 4'd5,
    CMD_STOP    = 4'd6,
    CMD_CLEAR   = 4'd7,
    CMD_PIN_ON  = 4'd8,
    CMD_PIN_OFF = 4'd9
  } cmd_e;

  localparam int CMD_W = 4;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  parameter int ADDR_W = 2,
  localparam int CNT_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              timeout,
  output logic [CNT_W-1:0]  period,
  output logic [BYTE_W-1:0] rdata,
  output logic              start_p,
  output logic              stop_p,
  output logic              clr_p,
  output logic              oneshot_q,
  output logic              route_q,
  output logic              irq_en_q,
  output logic              pend_q
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NBYTES);

  logic [BYTE_W-1:0] per_b [NBYTES];
  logic              ctl_wr;
  logic              ctl_rd;
  cmd_e              cmd;
  logic [BYTE_W-1:0] rd_mux;

  assign ctl_wr = wr_en && (addr == CTL_ADDR);
  assign ctl_rd = rd_en && (addr == CTL_ADDR);
  assign cmd    = cmd_e'(wdata[CMD_W-1:0]);

  // one byte register per slice of the period
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        per_b[i] <= '0;
      end else if (wr_en && addr == ADDR_W'(i)) begin
        per_b[i] <= wdata;
      end
    end
    assign period[i*BYTE_W +: BYTE_W] = per_b[i];
  end

  always_comb begin
    start_p = ctl_wr && (cmd == CMD_START);
    stop_p  = ctl_wr && (cmd == CMD_STOP);
    clr_p   = ctl_wr && (cmd == CMD_CLEAR);
  end

  // mode bits; the clear command restores defaults
  always_ff @(posedge clk) begin
    if (rst || clr_p) begin
      irq_en_q  <= 1'b0;
      oneshot_q <= 1'b0;
      route_q   <= 1'b0;
    end else if (ctl_wr) begin
      case (cmd)
        CMD_IRQ_ON:  irq_en_q  <= 1'b1;
        CMD_IRQ_OFF: irq_en_q  <= 1'b0;
        CMD_ONCE:    oneshot_q <= 1'b1;
        CMD_REPEAT:  oneshot_q <= 1'b0;
        CMD_PIN_ON:  route_q   <= 1'b1;
        CMD_PIN_OFF: route_q   <= 1'b0;
        default:     ;
      endcase
    end
  end

  // a new time-out outranks a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (rst || clr_p) begin
      pend_q <= 1'b0;
    end else if (timeout) begin
      pend_q <= 1'b1;
    end else if (ctl_rd) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (addr == ADDR_W'(i)) rd_mux = per_b[i];
    end
    if (addr == CTL_ADDR) rd_mux = BYTE_W'(irq_en_q & pend_q);
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      rdata <= '0;
    end else begin
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic             clr_p,
  input  logic             oneshot,
  input  logic             route,
  output logic             timeout,
  output logic [CNT_W-1:0] count_q,
  output logic             run_q,
  output logic             pin_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic per_zero;

  assign per_zero = (period == '0);
  assign timeout  = run_q && !per_zero && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst || clr_p) begin
      run_q   <= 1'b0;
      count_q <= '0;
    end else if (start_p && !per_zero) begin
      run_q   <= 1'b1;
      count_q <= period;
    end else if (stop_p || per_zero) begin
      run_q   <= 1'b0;
    end else if (run_q) begin
      if (count_q == ONE) begin
        count_q <= period;
        if (oneshot) run_q <= 1'b0;
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_p || !route) begin
      pin_q <= 1'b0;
    end else if (timeout) begin
      pin_q <= ~pin_q;
    end
  end
endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq,
  output logic              tmr_out
);
  localparam int CNT_W = BYTE_W * NBYTES;

  logic [CNT_W-1:0] period_w;
  logic [CNT_W-1:0] count_w;
  logic start_w, stop_w, clr_w;
  logic oneshot_w, route_w, irq_en_w, pend_w;
  logic timeout_w, running_w;

  ptmr_regs #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .timeout(timeout_w), .period(period_w), .rdata(rdata),
    .start_p(start_w), .stop_p(stop_w), .clr_p(clr_w),
    .oneshot_q(oneshot_w), .route_q(route_w), .irq_en_q(irq_en_w),
    .pend_q(pend_w)
  );

  ptmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .period(period_w), .start_p(start_w),
    .stop_p(stop_w), .clr_p(clr_w), .oneshot(oneshot_w), .route(route_w),
    .timeout(timeout_w), .count_q(count_w), .run_q(running_w),
    .pin_q(tmr_out)
  );

  assign irq = irq_en_w & pend_w;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int NBYTES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]       cmd_nib,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             timeout,
  input logic             start,
  input logic             stop,
  input logic             clr,
  input logic             oneshot,
  input logic             route,
  input logic             pend,
  input logic             irq,
  input logic             tmr_out
);
  localparam logic [ADDR_W-1:0] CTL = ADDR_W'(NBYTES);
  logic ctl_wr, ctl_rd;
  assign ctl_wr = wr_en && addr == CTL;
  assign ctl_rd = rd_en && addr == CTL;

  p_zero_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (period == '0) |-> !timeout);

  p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
    (running && !timeout && period != '0 && !start && !stop && !clr)
    |=> count == $past(count) - 1'b1);

  p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (rst)
    (timeout && oneshot && !start && !clr) |=> !running);

  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (timeout && !oneshot && !start && !stop && !clr)
    |=> (running || period == '0) && count == $past(period));

  p_tmo_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (timeout && !clr) |=> pend);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd && !timeout) |=> !pend);

  p_disable_drops_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && cmd_nib == 4'd2 && !timeout) |=> !irq);

  p_pin_low_r10: assert property (@(posedge clk) disable iff (rst)
    !route |=> !tmr_out);

  p_clear_defaults_r11: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!running && !irq && !tmr_out && period == $past(period)));
endmodule

bind period_timer ptmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .cmd_nib(wdata[3:0]), .period(period_w), .count(count_w),
  .running(running_w), .timeout(timeout_w), .start(start_w), .stop(stop_w),
  .clr(clr_w), .oneshot(oneshot_w), .route(route_w), .pend(pend_w),
  .irq(irq), .tmr_out(tmr_out)
);

// File: tb/period_timer_bench.sv
module period_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, tmr_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  period_timer u_period_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tmr_out(tmr_out)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic cmd(input logic [7:0] c);
    wr(2'd2, c);
  endtask

  // watch the pin for n cycles: first change index and number of changes
  task automatic watch(input int n, output int first, output int cnt);
    logic prev = tmr_out;
    first = 0; cnt = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (tmr_out != prev) begin
        if (cnt == 0) first = k;
        cnt++;
      end
      prev = tmr_out;
    end
  endtask

  task automatic set_period(input int p);
    wr(2'd0, 8'(p));
    wr(2'd1, 8'(p >> 8));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk(d, 0, "R1", "low byte after reset");
    rd(2'd1, d); chk(d, 0, "R1", "high byte after reset");
    rd(2'd2, d); chk(d, 0, "R1", "control after reset");
    chk(irq, 0, "R1", "irq after reset");
    chk(tmr_out, 0, "R1", "pin after reset");
  endtask

  task automatic t_period_rw();
    logic [7:0] d;
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
    rd(2'd0, d); chk(d, 8'hA5, "R2", "low byte readback");
    rd(2'd1, d); chk(d, 8'h3C, "R2", "high byte readback");
    rd(2'd3, d); chk(d, 0, "R2", "unused address");
  endtask

  task automatic t_retrig();
    int f, c;
    cmd(8'd7); set_period(5); cmd(8'd8); cmd(8'd5);
    watch(12, f, c);
    chk(f, 5, "R3", "first time-out after P=5");
    chk(c, 2, "R7", "periodic time-outs in 12 cycles");
    cmd(8'd7); set_period(16'h0100); cmd(8'd8); cmd(8'd5);
    watch(300, f, c);
    chk(f, 256, "R3", "high byte weight, P=256");
    chk(c, 1, "R10", "pin toggles per time-out");
  endtask

  task automatic t_oneshot();
    int f, c;
    cmd(8'd7); set_period(3); cmd(8'd8); cmd(8'd3); cmd(8'd5);
    watch(30, f, c);
    chk(f, 3, "R6", "single-shot time-out cycle");
    chk(c, 1, "R6", "single-shot count");
  endtask

  task automatic t_irq();
    logic [7:0] d;
    cmd(8'd7); set_period(4); cmd(8'd1);
    rd(2'd2, d); chk(d, 0, "R5", "enabled, nothing pending, no command echo");
    cmd(8'd5);                    // captured at E0; time-outs at E4, E8, E12
    repeat (6) @(negedge clk);
    rd(2'd2, d);                  // captured at E8, same edge as a time-out
    chk(d, 1, "R5", "control read with pending irq");
    chk(irq, 1, "R8", "time-out beats read in same cycle");
    rd(2'd2, d);                  // captured at E10
    chk(d, 1, "R8", "pending held across same-cycle read");
    chk(irq, 0, "R8", "read clears pending");
    cmd(8'd2);                    // captured at E12 with a time-out
    chk(irq, 0, "R9", "disable drops irq");
    cmd(8'd1);                    // captured at E14
    chk(irq, 1, "R9", "re-enable restores pending irq");
    cmd(8'd6);
  endtask

  task automatic t_zero();
    int f, c;
    cmd(8'd7); set_period(0); cmd(8'd8); cmd(8'd1); cmd(8'd5);
    watch(20, f, c);
    chk(c, 0, "R4", "zero period start ignored");
    chk(irq, 0, "R4", "no irq with zero period");
    set_period(3); cmd(8'd5); wr(2'd0, 8'd0);
    watch(20, f, c);
    chk(c, 0, "R4", "period cleared while running");
  endtask

  task automatic t_clear_cmd();
    int f, c;
    logic [7:0] d;
    cmd(8'd7); set_period(3); cmd(8'd3); cmd(8'd8); cmd(8'd1); cmd(8'd5);
    repeat (4) @(negedge clk);
    chk(irq, 1, "R11", "irq pending before clear");
    cmd(8'd7);
    chk(irq, 0, "R11", "irq after clear");
    chk(tmr_out, 0, "R11", "pin after clear");
    rd(2'd0, d); chk(d, 3, "R11", "period kept by clear");
    cmd(8'd8);
    watch(10, f, c); chk(c, 0, "R11", "stopped after clear");
    cmd(8'd5);
    watch(7, f, c); chk(c, 2, "R11", "re-triggerable restored");
    cmd(8'd6);
  endtask

  task automatic t_stop_ignored();
    int f, c;
    logic [7:0] d;
    cmd(8'd7); set_period(3); cmd(8'd8); cmd(8'd5);
    watch(4, f, c); chk(c, 1, "R12", "running before stop");
    cmd(8'd6);
    watch(10, f, c); chk(c, 0, "R12", "stop halts");
    cmd(8'h00); cmd(8'h0A); cmd(8'h0F); cmd(8'hF0);
    watch(10, f, c); chk(c, 0, "R12", "unused codes ignored");
    rd(2'd2, d); chk(d, 0, "R12", "unused codes leave status");
    cmd(8'h25);
    watch(4, f, c); chk(f, 3, "R12", "reserved bits ignored on start");
    cmd(8'd9);
    @(negedge clk);
    chk(tmr_out, 0, "R10", "unrouted pin low");
    watch(10, f, c); chk(c, 0, "R10", "unrouted pin stays low");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_period_rw();
    t_retrig();
    t_oneshot();
    t_irq();
    t_zero();
    t_clear_cmd();
    t_stop_ignored();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule